// File: doc/BRIEF.md
# Configuration Phase Sequencer

This block steps a programmable device through its four life phases: initialization, configuration, start-up and operation. It watches two active-low request lines (a load reset and a program request), a readiness line that the device's initialization logic raises when it is ready, and a mode select that picks master or slave loading. Configuration clocks arrive as single-cycle enable pulses on the block's clock, each carrying one serial data bit and, on the last frame, an end-of-load strobe.

While loading, the block counts configuration clocks from zero, picks a length value out of the bit stream, and declares the load finished only when the count matches that length and the end frame has been seen. A fixed four-clock start-up then raises the done flag, releases the global set/reset hold and drives the I/O out of tristate. Which request can restart the device depends on the phase it is in.

Top module: `cfg_seq`

## Requirements
- R1: An active-low asynchronous reset rst_ni puts the phase output at initialization (code 0), with done_o low and gsr_hold_o and io_tri_o high. Phase codes: 0 initialization, 1 configuration, 2 start-up, 3 operation.
- R2: Initialization is left only when load_rst_ni, prog_ni and init_i are all high; in slave mode (master_i low) the phase becomes configuration at the first clock edge that samples all three high.
- R3: In master mode the block stays in initialization for EXTRA_CYC (default 6) more clock edges than in slave mode after the three conditions of R2 hold; dropping any of them restarts that wait.
- R4: In configuration, a low level on either load_rst_ni or prog_ni returns the phase to initialization at the next clock edge.
- R5: In start-up and operation, a low load_rst_ni has no effect on the phase; a low prog_ni returns the phase to initialization at the next clock edge.
- R6: The length value is the LEN_W bits that follow PRE_BITS preamble bits in the stream, most significant bit first, one bit taken from din_i on each cclk_en_i pulse.
- R7: The configuration clock count is cleared whenever the phase is not configuration and rises by one on each cclk_en_i pulse while in configuration, so every new load counts from zero.
- R8: Configuration ends, with the phase becoming start-up at the clock edge after the last needed pulse, only when the length value is complete, the count equals it, and eoc_i has been seen high on a pulse; a count match without the end frame, or the end frame before the match, keeps the phase in configuration.
- R9: In initialization and configuration, gsr_hold_o and io_tri_o stay high and done_o stays low.
- R10: In start-up done_o is high from its first cycle; after SU_CLKS (default 4) cclk_en_i pulses the phase becomes operation, and on that same edge gsr_hold_o and io_tri_o fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| load_rst_ni | input | 1 | Load reset request, active low |
| prog_ni | input | 1 | Program request, active low |
| init_i | input | 1 | Initialization ready line |
| master_i | input | 1 | High selects master loading |
| cclk_en_i | input | 1 | One-cycle pulse per configuration clock |
| din_i | input | 1 | Serial configuration data bit |
| eoc_i | input | 1 | End-of-configuration frame strobe, sampled on a pulse |
| phase_o | output | 2 | Current phase code |
| done_o | output | 1 | Load finished flag |
| gsr_hold_o | output | 1 | Global set/reset hold |
| io_tri_o | output | 1 | I/O tristate enable |

## Verification
The bench builds the block with PRE_BITS 4 and LEN_W 8, so a whole length field arrives within twelve configuration clocks and loads of 20 and 37 clocks end quickly while still placing the count match well after the field closes. EXTRA_CYC and SU_CLKS keep their defaults of 6 and 4, so the exact edge at which master mode leaves initialization and the start-up length are checked at their real values. Aborts are applied mid-load, and a second full load after an abort shows the count restarting from zero.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  typedef enum logic [1:0] {
    PH_INIT    = 2'd0,
    PH_CFG     = 2'd1,
    PH_STARTUP = 2'd2,
    PH_OPER    = 2'd3
  } phase_e;
endpackage

// File: rtl/cfg_seq_init_wait.sv
module cfg_seq_init_wait #(
  parameter int EXTRA_CYC = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic ready_i,
  input  logic master_i,
  output logic go_o
);
  localparam int W = $clog2(EXTRA_CYC + 1);

  logic [W-1:0] wait_q;
  logic         wait_done;

  assign wait_done = (wait_q == W'(EXTRA_CYC));
  assign go_o      = active_i && ready_i && (!master_i || wait_done);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    wait_q <= '0;
    else if (!active_i || !ready_i || !master_i)    wait_q <= '0;
    else if (!wait_done)                            wait_q <= wait_q + 1'b1;
  end
endmodule

// File: rtl/cfg_seq_len_track.sv
module cfg_seq_len_track #(
  parameter int PRE_BITS = 8,
  parameter int LEN_W    = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic cclk_en_i,
  input  logic din_i,
  input  logic eoc_i,
  output logic complete_o
);
  localparam int CNT_W     = LEN_W;
  localparam int FIELD_END = PRE_BITS + LEN_W - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q;
  logic             len_valid_q;
  logic             eoc_seen_q;
  logic             in_field;
  logic             pulse;

  assign pulse    = active_i && cclk_en_i;
  assign in_field = !len_valid_q && (cnt_q >= CNT_W'(PRE_BITS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      len_q       <= '0;
      len_valid_q <= 1'b0;
      eoc_seen_q  <= 1'b0;
    end else if (!active_i) begin
      cnt_q       <= '0;
      len_q       <= '0;
      len_valid_q <= 1'b0;
      eoc_seen_q  <= 1'b0;
    end else if (pulse) begin
      cnt_q <= cnt_q + 1'b1;
      if (in_field) begin
        len_q <= {len_q[LEN_W-2:0], din_i};
        if (cnt_q == CNT_W'(FIELD_END)) len_valid_q <= 1'b1;
      end
      if (eoc_i) eoc_seen_q <= 1'b1;
    end
  end

  // Compare only once the field is latched
  assign complete_o = active_i && len_valid_q && eoc_seen_q && (cnt_q == len_q);
endmodule

// File: rtl/cfg_seq_startup.sv
module cfg_seq_startup #(
  parameter int SU_CLKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic cclk_en_i,
  output logic last_o
);
  localparam int W = $clog2(SU_CLKS + 1);

  logic [W-1:0] su_q;

  assign last_o = active_i && cclk_en_i && (su_q == W'(SU_CLKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       su_q <= '0;
    else if (!active_i)                su_q <= '0;
    else if (cclk_en_i && !last_o)     su_q <= su_q + 1'b1;
  end
endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
  import cfg_seq_pkg::*;
#(
  parameter int PRE_BITS  = 8,
  parameter int LEN_W     = 24,
  parameter int EXTRA_CYC = 6,
  parameter int SU_CLKS   = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_rst_ni,
  input  logic       prog_ni,
  input  logic       init_i,
  input  logic       master_i,
  input  logic       cclk_en_i,
  input  logic       din_i,
  input  logic       eoc_i,
  output logic [1:0] phase_o,
  output logic       done_o,
  output logic       gsr_hold_o,
  output logic       io_tri_o
);
  phase_e phase_q, phase_d;
  logic   init_go, load_complete, su_last;
  logic   reqs_idle;

  assign reqs_idle = load_rst_ni && prog_ni;

  cfg_seq_init_wait #(.EXTRA_CYC(EXTRA_CYC)) u_init_wait (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (phase_q == PH_INIT),
    .ready_i  (reqs_idle && init_i),
    .master_i (master_i),
    .go_o     (init_go)
  );

  cfg_seq_len_track #(.PRE_BITS(PRE_BITS), .LEN_W(LEN_W)) u_len_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (phase_q == PH_CFG),
    .cclk_en_i  (cclk_en_i),
    .din_i      (din_i),
    .eoc_i      (eoc_i),
    .complete_o (load_complete)
  );

  cfg_seq_startup #(.SU_CLKS(SU_CLKS)) u_startup (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (phase_q == PH_STARTUP),
    .cclk_en_i (cclk_en_i),
    .last_o    (su_last)
  );

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_INIT:    if (init_go) phase_d = PH_CFG;
      PH_CFG: begin
        if (!reqs_idle)         phase_d = PH_INIT;
        else if (load_complete) phase_d = PH_STARTUP;
      end
      PH_STARTUP: begin
        // load reset is ignored once loading is over
        if (!prog_ni)      phase_d = PH_INIT;
        else if (su_last)  phase_d = PH_OPER;
      end
      PH_OPER:    if (!prog_ni) phase_d = PH_INIT;
      default:    phase_d = PH_INIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_INIT;
    else         phase_q <= phase_d;
  end

  assign phase_o    = phase_q;
  assign done_o     = (phase_q == PH_STARTUP) || (phase_q == PH_OPER);
  assign gsr_hold_o = (phase_q != PH_OPER);
  assign io_tri_o   = (phase_q != PH_OPER);
endmodule

// File: rtl/cfg_seq_chk.sv
module cfg_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       load_rst_ni,
  input logic       prog_ni,
  input logic       init_i,
  input logic       phase_o,
  input logic [1:0] phase_v,
  input logic       done_o,
  input logic       gsr_hold_o,
  input logic       io_tri_o
);
  localparam logic [1:0] P_INIT = 2'd0, P_CFG = 2'd1, P_SU = 2'd2, P_OPER = 2'd3;

  a_r4_cfg_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_v == P_CFG) && (!load_rst_ni || !prog_ni) |=> (phase_v == P_INIT));

  a_r5_load_rst_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((phase_v == P_SU) || (phase_v == P_OPER)) && prog_ni |=> (phase_v != P_INIT));

  a_r5_prog_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((phase_v == P_SU) || (phase_v == P_OPER)) && !prog_ni |=> (phase_v == P_INIT));

  a_r2_entry_needs_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_v == P_INIT) ##1 (phase_v == P_CFG) |-> $past(load_rst_ni && prog_ni && init_i));

  a_r9_held_while_loading: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((phase_v == P_INIT) || (phase_v == P_CFG)) |-> (gsr_hold_o && io_tri_o && !done_o));

  a_r10_done_in_startup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_v == P_SU) |-> (done_o && gsr_hold_o && io_tri_o));

  a_r10_released_in_oper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_v == P_OPER) |-> (done_o && !gsr_hold_o && !io_tri_o));

  a_r8_no_skip_to_oper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_v == P_CFG) |=> (phase_v != P_OPER));
endmodule

bind cfg_seq cfg_seq_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .load_rst_ni (load_rst_ni),
  .prog_ni     (prog_ni),
  .init_i      (init_i),
  .phase_o     (phase_o[0]),
  .phase_v     (phase_o),
  .done_o      (done_o),
  .gsr_hold_o  (gsr_hold_o),
  .io_tri_o    (io_tri_o)
);

// File: tb/cfg_seq_tb_top.sv
module cfg_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PRE  = 4;
  localparam int LW   = 8;
  localparam int EXTRA = 6;
  localparam int SU   = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic load_rst_ni = 1'b1, prog_ni = 1'b0, init_i = 1'b0, master_i = 1'b0;
  logic cclk_en_i = 1'b0, din_i = 1'b0, eoc_i = 1'b0;
  logic [1:0] phase_o;
  logic done_o, gsr_hold_o, io_tri_o;

  int n_vec = 0, n_err = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cfg_seq #(.PRE_BITS(PRE), .LEN_W(LW), .EXTRA_CYC(EXTRA), .SU_CLKS(SU)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_rst_ni(load_rst_ni), .prog_ni(prog_ni),
    .init_i(init_i), .master_i(master_i), .cclk_en_i(cclk_en_i), .din_i(din_i),
    .eoc_i(eoc_i), .phase_o(phase_o), .done_o(done_o), .gsr_hold_o(gsr_hold_o),
    .io_tri_o(io_tri_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic outs(input string req, input int ph, input bit dn, input bit hold);
    chk({req, " phase"}, phase_o, ph);
    chk({req, " done"}, done_o, dn);
    chk({req, " gsr_hold"}, gsr_hold_o, hold);
    chk({req, " io_tri"}, io_tri_o, hold);
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  // one configuration clock pulse; k is the zero-based bit index
  task automatic pulse_bit(input int k, input int len, input bit eoc);
    cclk_en_i = 1'b1;
    eoc_i = eoc;
    if (k < PRE) din_i = 1'b1;
    else if (k < PRE + LW) din_i = len[PRE+LW-1-k];
    else din_i = 1'b0;
    tick(1);
    cclk_en_i = 1'b0; eoc_i = 1'b0; din_i = 1'b0;
    tick(1);
  endtask

  task automatic feed(input int from, input int to, input int len, input int eoc_at);
    for (int k = from; k < to; k++) pulse_bit(k, len, (k == eoc_at - 1));
  endtask

  task automatic t_reset;
    tick(2);
    outs("R1 reset", 0, 0, 1);
    rst_ni = 1'b1;
    tick(1);
    outs("R1 after release", 0, 0, 1);
  endtask

  task automatic t_slave_entry;
    init_i = 1'b1;   // prog still low
    tick(5);
    chk("R2 prog low holds init", phase_o, 0);
    prog_ni = 1'b1;
    tick(1);
    chk("R2 slave enters cfg next edge", phase_o, 1);
    outs("R9 cfg outputs", 1, 0, 1);
  endtask

  task automatic t_full_load;
    feed(0, 19, 20, 18);
    tick(3);
    chk("R8 eoc before count match stays cfg", phase_o, 1);
    feed(19, 20, 20, 0);
    chk("R7 R8 count match with eoc -> startup", phase_o, 2);
    outs("R10 startup first cycle", 2, 1, 1);
    for (int i = 0; i < SU - 1; i++) pulse_bit(0, 0, 1'b0);
    chk("R10 startup lasts four clocks", phase_o, 2);
    pulse_bit(0, 0, 1'b0);
    outs("R10 operation", 3, 1, 0);
  endtask

  task automatic t_oper_rules;
    load_rst_ni = 1'b0;
    tick(4);
    chk("R5 load reset ignored in operation", phase_o, 3);
    load_rst_ni = 1'b1;
    prog_ni = 1'b0;
    tick(1);
    outs("R5 prog restarts from operation", 0, 0, 1);
    prog_ni = 1'b1;
    tick(1);
    chk("R2 reentry after prog", phase_o, 1);
  endtask

  task automatic t_cfg_abort;
    feed(0, 10, 20, 0);
    load_rst_ni = 1'b0;
    tick(1);
    chk("R4 load reset aborts cfg", phase_o, 0);
    tick(2);
    chk("R2 load reset low holds init", phase_o, 0);
    load_rst_ni = 1'b1;
    tick(1);
    chk("R2 reenter cfg", phase_o, 1);
    feed(0, 25, 20, 0);
    tick(3);
    chk("R8 count passes length without eoc stays cfg", phase_o, 1);
    prog_ni = 1'b0;
    tick(1);
    chk("R4 prog aborts cfg", phase_o, 0);
    prog_ni = 1'b1;
    tick(1);
    chk("R7 reentry clears count", phase_o, 1);
    feed(0, 36, 37, 37);
    tick(2);
    chk("R6 length 37 not yet reached", phase_o, 1);
    feed(36, 37, 37, 37);
    chk("R6 R7 length 37 with eoc -> startup", phase_o, 2);
    load_rst_ni = 1'b0;
    tick(2);
    chk("R5 load reset ignored in startup", phase_o, 2);
    load_rst_ni = 1'b1;
    prog_ni = 1'b0;
    tick(1);
    chk("R5 prog restarts from startup", phase_o, 0);
  endtask

  task automatic t_master;
    master_i = 1'b1;
    init_i = 1'b0;
    prog_ni = 1'b1;
    tick(3);
    chk("R2 init low holds init", phase_o, 0);
    init_i = 1'b1;
    tick(3);
    init_i = 1'b0;      // restart the wait
    tick(1);
    init_i = 1'b1;
    tick(EXTRA);
    chk("R3 master still init after six edges", phase_o, 0);
    tick(1);
    chk("R3 master enters cfg on seventh edge", phase_o, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_err++; n_vec++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_slave_entry();
    t_full_load();
    t_oper_rules();
    t_cfg_abort();
    t_master();
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule